// File: doc/BRIEF.md
# Power and Sleep State Controller

This block owns the clock-enable and reset pins of a set of peripheral modules, which are grouped into power domains. Software sets each module's target state through a simple synchronous register bus and can ask for an off domain to be switched on. Nothing changes when these registers are written. The new values are held as pending requests until software writes a per-domain go bit into the command register.

When a domain is commanded, it reports busy. If the domain is off and its power-up request is set, it first spends a fixed number of cycles powering up. It then spends the same number of cycles settling the modules. After that, every module in the domain takes on its requested state, and the busy bit drops. The number of modules, the number of domains and the transition length are all parameters. Module `m` belongs to domain `m mod NUM_DOM`.

The register bus is a plain control path with no back-pressure. A write takes effect at the clock edge where `bus_sel` and `bus_wr` are both high. A read is requested with `bus_sel` high and `bus_wr` low, and its data appears on `bus_rdata` one cycle later.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: After reset, domain 0 is on and every other domain is off. Every module is in state 0 with `mod_clk_en` and `mod_rst_n` low, and the transition status register reads 0.
- R2: Register layout uses byte offsets, with array entries 4 bytes apart: command 0x120, transition status 0x128, domain status 0x200+4d, domain control 0x300+4d, module status 0x800+4m, module control 0xA00+4m. Module control reads back exactly what was written, with the state in bits 5:0, the local-reset-release bit in bit 8 and the force bit in bit 31. Domain control reads back its power-up request in bit 0. Read data arrives one cycle after the request.
- R3: The command register and any unmapped offset (including offsets not 4-byte aligned and indices past the last module or domain) read as zero.
- R4: Writes to module control or domain control change no output and no status register until a command for the owning domain is issued.
- R5: Writing 1 to command bit d sets transition status bit d. If the domain is on, the outputs and module status of its modules change at the TRANS_CYC-th clock edge after the write edge, and bit d clears at that same edge.
- R6: A command for domain d affects only modules m with m mod NUM_DOM = d.
- R7: State codes are 0 (software reset, clock off), 1 (synchronous reset), 2 (clock off, out of reset) and 3 (running). `mod_clk_en` is 1 only in state 3 with the domain on. Module status bit 12 mirrors `mod_clk_en`.
- R8: `mod_rst_n` is 1 only in state 2 or 3 with the applied local-reset-release bit at 1. A module enabled with bit 8 = 0 runs its clock while held in reset.
- R9: Commanding an off domain whose power-up request is 1 raises `dom_pwr_on` and domain status after TRANS_CYC edges. Module changes follow after another TRANS_CYC edges. A domain once on stays on.
- R10: Commanding an off domain without a power-up request still runs a TRANS_CYC busy window. At the end of that window, modules without the force bit keep their state. Modules with the force bit take their requested state, but their clock stays gated.
- R11: A command to a busy domain is ignored, so the completion edge of the running transition does not move.
- R12: Domain status reads 1 when the domain is on and 0 when it is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after a read |
| mod_clk_en | output | NUM_MOD | Per-module clock enable |
| mod_rst_n | output | NUM_MOD | Per-module active-low reset |
| dom_pwr_on | output | NUM_DOM | Per-domain power-on control |

## Verification
The bench builds the block with NUM_MOD=4, NUM_DOM=2 and TRANS_CYC=4. This is small enough to sweep every module through all four state codes with both values of the local-reset-release bit. The sweep checks all outputs on the edge before each transition ends and again on the edge where it ends. With two domains, domain 1 starts off, which brings both the forced and unforced off-domain cases and the two-phase power-up within reach. A TRANS_CYC of 4 leaves room to land a second command inside a running window and show that the completion edge does not move.

// File: rtl/psc_pkg.sv
package psc_pkg;
  localparam int STATE_W = 6;

  localparam logic [11:0] OFF_CMD   = 12'h120;
  localparam logic [11:0] OFF_BUSY  = 12'h128;
  localparam logic [11:0] OFF_DSTAT = 12'h200;
  localparam logic [11:0] OFF_DCTL  = 12'h300;
  localparam logic [11:0] OFF_MSTAT = 12'h800;
  localparam logic [11:0] OFF_MCTL  = 12'hA00;

  localparam int BIT_FORCE  = 31;
  localparam int BIT_LREL   = 8;
  localparam int BIT_CLKRUN = 12;

  localparam logic [STATE_W-1:0] ST_SWRST = 6'd0;
  localparam logic [STATE_W-1:0] ST_SYNC  = 6'd1;
  localparam logic [STATE_W-1:0] ST_GATED = 6'd2;
  localparam logic [STATE_W-1:0] ST_RUN   = 6'd3;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_PWR, SEQ_MOD} seq_e;
endpackage

// File: rtl/psc_dom_seq.sv
module psc_dom_seq
  import psc_pkg::*;
#(
  parameter int TRANS_CYC = 8,
  parameter bit START_ON  = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic next_wr,
  input  logic next_wdata,
  output logic next_q,
  output logic busy,
  output logic dom_on,
  output logic apply
);
  localparam int CW = $clog2(TRANS_CYC + 1);
  localparam logic [CW-1:0] RELOAD = CW'(TRANS_CYC - 1);

  seq_e          phase;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= SEQ_IDLE;
      cnt    <= '0;
      dom_on <= START_ON;
      next_q <= 1'b0;
    end else begin
      if (next_wr) next_q <= next_wdata;
      case (phase)
        SEQ_IDLE: if (go) begin
          phase <= (!dom_on && next_q) ? SEQ_PWR : SEQ_MOD;
          cnt   <= RELOAD;
        end
        SEQ_PWR: if (cnt == '0) begin
          dom_on <= 1'b1;
          phase  <= SEQ_MOD;
          cnt    <= RELOAD;
        end else begin
          cnt <= cnt - 1'b1;
        end
        SEQ_MOD: if (cnt == '0) phase <= SEQ_IDLE;
                 else cnt <= cnt - 1'b1;
        default: phase <= SEQ_IDLE;
      endcase
    end
  end

  assign busy  = (phase != SEQ_IDLE);
  assign apply = (phase == SEQ_MOD) && (cnt == '0);

  // R9
  pwr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dom_on) |-> phase == SEQ_MOD);
  // R9
  pwr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dom_on |=> dom_on);
  // R5
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> !busy);
  // R11
  go_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && go && !apply |=> busy);
endmodule

// File: rtl/psc_mod_slot.sv
module psc_mod_slot
  import psc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_wr,
  input  logic [STATE_W-1:0] wr_state,
  input  logic               wr_lrel,
  input  logic               wr_force,
  input  logic               apply,
  input  logic               dom_on,
  output logic [31:0]        ctl_rd,
  output logic [STATE_W-1:0] cur_state,
  output logic               clk_en,
  output logic               rst_out_n
);
  logic [STATE_W-1:0] req_state;
  logic               req_lrel, req_force, cur_lrel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_state <= ST_SWRST;
      req_lrel  <= 1'b1;
      req_force <= 1'b0;
      cur_state <= ST_SWRST;
      cur_lrel  <= 1'b1;
    end else begin
      if (ctl_wr) begin
        req_state <= wr_state;
        req_lrel  <= wr_lrel;
        req_force <= wr_force;
      end
      if (apply && (dom_on || req_force)) begin
        cur_state <= req_state;
        cur_lrel  <= req_lrel;
      end
    end
  end

  assign ctl_rd    = {req_force, 22'b0, req_lrel, 2'b0, req_state};
  assign clk_en    = (cur_state == ST_RUN) && dom_on;
  assign rst_out_n = ((cur_state == ST_GATED) || (cur_state == ST_RUN)) && cur_lrel;

  // R4
  hold_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable(cur_state) && $stable(cur_lrel));
  // R10
  off_noforce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    apply && !dom_on && !req_force && !ctl_wr |=> $stable(cur_state));
endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
  import psc_pkg::*;
#(
  parameter int NUM_MOD   = 4,
  parameter int NUM_DOM   = 2,
  parameter int TRANS_CYC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [11:0]        bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic [NUM_MOD-1:0] mod_clk_en,
  output logic [NUM_MOD-1:0] mod_rst_n,
  output logic [NUM_DOM-1:0] dom_pwr_on
);
  logic wr_any, rd_any, wr_cmd;
  logic [NUM_DOM-1:0] busy, apply, next_q;
  logic [STATE_W-1:0] cur_st [NUM_MOD];
  logic [31:0]        ctl_rd [NUM_MOD];
  logic [31:0]        rd_mux;
  logic               unused_wdata;

  assign wr_any       = bus_sel && bus_wr;
  assign rd_any       = bus_sel && !bus_wr;
  assign wr_cmd       = wr_any && (bus_addr == OFF_CMD);
  assign unused_wdata = ^bus_wdata;

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    psc_dom_seq #(.TRANS_CYC(TRANS_CYC), .START_ON(d == 0)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .go(wr_cmd && bus_wdata[d]),
      .next_wr(wr_any && (bus_addr == OFF_DCTL + 12'(4 * d))),
      .next_wdata(bus_wdata[0]),
      .next_q(next_q[d]), .busy(busy[d]),
      .dom_on(dom_pwr_on[d]), .apply(apply[d]));
  end

  for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
    localparam int DOM = m % NUM_DOM;
    psc_mod_slot u_slot (
      .clk(clk), .rst_n(rst_n),
      .ctl_wr(wr_any && (bus_addr == OFF_MCTL + 12'(4 * m))),
      .wr_state(bus_wdata[STATE_W-1:0]),
      .wr_lrel(bus_wdata[BIT_LREL]),
      .wr_force(bus_wdata[BIT_FORCE]),
      .apply(apply[DOM]), .dom_on(dom_pwr_on[DOM]),
      .ctl_rd(ctl_rd[m]), .cur_state(cur_st[m]),
      .clk_en(mod_clk_en[m]), .rst_out_n(mod_rst_n[m]));
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == OFF_BUSY) rd_mux = 32'(busy);
    for (int i = 0; i < NUM_DOM; i++) begin
      if (bus_addr == OFF_DSTAT + 12'(4 * i)) rd_mux = {31'b0, dom_pwr_on[i]};
      if (bus_addr == OFF_DCTL + 12'(4 * i))  rd_mux = {31'b0, next_q[i]};
    end
    for (int i = 0; i < NUM_MOD; i++) begin
      if (bus_addr == OFF_MSTAT + 12'(4 * i))
        rd_mux = {19'b0, mod_clk_en[i], 6'b0, cur_st[i]};
      if (bus_addr == OFF_MCTL + 12'(4 * i)) rd_mux = ctl_rd[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_any ? rd_mux : '0;
  end

  // R3
  cmd_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_any && (bus_addr == OFF_CMD) |=> bus_rdata == '0);
  // R3
  misaligned_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_any && (bus_addr[1:0] != 2'b00) |=> bus_rdata == '0);
endmodule

// File: tb/sim_pwr_sleep_ctrl.sv
module sim_pwr_sleep_ctrl;
  localparam int NM = 4, ND = 2, TC = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, bus_sel, bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata, rv;
  logic [NM-1:0] mod_clk_en, mod_rst_n;
  logic [ND-1:0] dom_pwr_on;

  pwr_sleep_ctrl #(.NUM_MOD(NM), .NUM_DOM(ND), .TRANS_CYC(TC)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mod_clk_en(mod_clk_en), .mod_rst_n(mod_rst_n), .dom_pwr_on(dom_pwr_on));

  int checks = 0, fails = 0;
  bit done = 0;
  int exp_st [NM];
  int exp_l  [NM];
  int exp_on [ND];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0; d = bus_rdata;
  endtask

  task automatic skip(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic exp_ce(int m);
    return (exp_st[m] == 3) && (exp_on[m % ND] != 0);
  endfunction

  task automatic check_outs(string req);
    for (int m = 0; m < NM; m++) begin
      chk(req, {31'b0, mod_clk_en[m]}, {31'b0, exp_ce(m)});
      chk(req, {31'b0, mod_rst_n[m]}, {31'b0, (exp_st[m] >= 2) && (exp_l[m] != 0)});
    end
    for (int d = 0; d < ND; d++) chk(req, {31'b0, dom_pwr_on[d]}, 32'(exp_on[d]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    for (int m = 0; m < NM; m++) begin exp_st[m] = 0; exp_l[m] = 1; end
    exp_on[0] = 1; exp_on[1] = 0;
    skip(3); rst_n = 1; skip(1);

    // R1 reset state
    check_outs("R1");
    rd(12'h128, rv); chk("R1", rv, 0);
    rd(12'h800, rv); chk("R1", rv, 0);
    // R12 domain status
    rd(12'h200, rv); chk("R12", rv, 1);
    rd(12'h204, rv); chk("R12", rv, 0);

    // R3 unmapped and command reads
    rd(12'h120, rv); chk("R3", rv, 0);
    rd(12'h802, rv); chk("R3", rv, 0);
    rd(12'h130, rv); chk("R3", rv, 0);
    rd(12'h810, rv); chk("R3", rv, 0);
    rd(12'h208, rv); chk("R3", rv, 0);

    // R2 readback, R4 pending has no effect
    wr(12'hA00, 32'h8000_0003);
    rd(12'hA00, rv); chk("R2", rv, 32'h8000_0003);
    check_outs("R4");
    rd(12'h800, rv); chk("R4", rv, 0);
    wr(12'hA00, 32'h0000_0100);
    wr(12'h304, 32'h1);
    rd(12'h304, rv); chk("R2", rv, 1);
    rd(12'h204, rv); chk("R4", rv, 0);
    check_outs("R4");
    wr(12'h304, 32'h0);

    // R10 off domain without power-up request
    wr(12'hA04, 32'h0000_0103);
    wr(12'hA0C, 32'h8000_0102);
    wr(12'h120, 32'h2);
    skip(2 * TC + 2);
    exp_st[3] = 2; exp_l[3] = 1;
    rd(12'h804, rv); chk("R10", rv, 0);
    rd(12'h80C, rv); chk("R10", rv, 2);
    rd(12'h204, rv); chk("R10", rv, 0);
    check_outs("R10");

    // R9 power-up then module change
    wr(12'h304, 32'h1);
    wr(12'h120, 32'h2);
    skip(TC - 1); chk("R9", {31'b0, dom_pwr_on[1]}, 0);
    skip(1);      chk("R9", {31'b0, dom_pwr_on[1]}, 1);
    skip(TC - 1); chk("R9", {31'b0, mod_clk_en[1]}, 0);
    skip(1);      chk("R9", {31'b0, mod_clk_en[1]}, 1);
    exp_on[1] = 1; exp_st[1] = 3;
    check_outs("R9");
    rd(12'h204, rv); chk("R12", rv, 1);

    // R5 busy status
    wr(12'h120, 32'h1);
    rd(12'h128, rv); chk("R5", rv, 1);
    skip(2 * TC);
    rd(12'h128, rv); chk("R5", rv, 0);

    // R5 R6 R7 R8 sweep over modules, states, local reset bit
    for (int m = 0; m < NM; m++) begin
      for (int s = 0; s < 4; s++) begin
        for (int l = 0; l < 2; l++) begin
          wr(12'hA00 + 12'(4 * m), 32'((l << 8) | s));
          wr(12'h120, 32'(1 << (m % ND)));
          skip(TC - 1);
          check_outs("R6");
          skip(1);
          exp_st[m] = s; exp_l[m] = l;
          check_outs("R5");
          // R8 covered by rst_n compare above with l=0 in state 3
          rd(12'h800 + 12'(4 * m), rv);
          chk("R7", rv, 32'(s) | (32'(exp_ce(m)) << 12));
        end
      end
    end

    // R11 second command during busy window
    wr(12'hA00, 32'h0000_0102);
    wr(12'h120, 32'h1);
    wr(12'h120, 32'h1);
    skip(TC - 3); chk("R11", {31'b0, mod_clk_en[0]}, 1);
    skip(1);      chk("R11", {31'b0, mod_clk_en[0]}, 0);
    chk("R11", {31'b0, mod_rst_n[0]}, 1);
    skip(TC);
    rd(12'h128, rv); chk("R11", rv, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule